// File: doc/BRIEF.md
# Host Attribute-Space Access Decoder

This block is the host-facing port into a small attribute space made of a 256-byte configuration RAM and eight byte-wide configuration registers. An access is allowed only when three active-low conditions are true together: the card enable is low, the register-space select is low and the lowest host address bit is zero. Only even host addresses reach the space. Host address bits 9 down to 1 form a word index. Indices 0 to 255 address the RAM, 256 to 263 address configuration registers 0 to 7, and any higher index addresses nothing.

The host strobes are sampled on the block clock and tracked by a three-state access machine:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No access in progress. |
| `ST_READ` | An enabled read is being served. |
| `ST_WRITE` | An enabled write strobe is held low. |

| Transition | Condition |
|------------|-----------|
| IDLE→WRITE | Access enabled and write strobe low. |
| IDLE→READ | Access enabled, output enable low, write strobe high. |
| READ→READ | The read conditions still hold. |
| READ→WRITE | Write pre-emption: the write strobe falls while access is enabled. |
| READ→IDLE | The read conditions are lost. |
| WRITE→WRITE | The strobe is held low and access stays enabled. |
| WRITE→IDLE (commit) | The write strobe rises while access is still enabled. |
| WRITE→IDLE (abort) | Access is lost before the strobe rises, or when it rises. |

A write lands on the strobe's rising edge, as seen by the clock. It uses the address and data that were present in the last cycle the strobe was low. Read data is registered and is presented with a drive-enable flag.

Top module: `attr_host_port`

## Requirements
- R1: When `host_ce1_n` is 1, `host_reg_n` is 1 or `host_a[0]` is 1, the block asserts no select, drives no read data (`host_rdata_oe` stays 0) and changes no storage.
- R2: With access enabled, index `host_a[9:1]` in 0..255 addresses RAM word `host_a[8:1]`, and `ram_sel` is 1 while either strobe is low.
- R3: With access enabled, index 256..263 addresses configuration register `host_a[3:1]`. `reg_sel` then has exactly that bit set while a strobe is low, and at most one select of `ram_sel`/`reg_sel` is ever 1.
- R4: An enabled index above 263 asserts no select, a write to it changes nothing, and a read from it returns 0x00 with `host_rdata_oe` at 1.
- R5: A write commits on the first clock edge at which `host_we_n` is sampled 1 after the machine is in `ST_WRITE`, with access still enabled. It stores the address and data sampled at the last edge where `host_we_n` was 0, so the last value held wins.
- R6: If access becomes disabled while `host_we_n` is still 0, the write is aborted. The machine returns to `ST_IDLE` and nothing is stored.
- R7: A read sampled at a clock edge (access enabled, `host_oe_n` 0, `host_we_n` 1) sets `host_rdata_oe` to 1 and `host_rdata` to the addressed byte from that edge on. Before that edge `host_rdata_oe` is 0.
- R8: When both strobes are low with access enabled, the write wins: from the next edge `host_rdata_oe` is 0, and the write later commits as in R5.
- R9: `rst_n` low asynchronously clears the eight configuration registers to 0x00, returns the machine to `ST_IDLE` and forces `host_rdata_oe` and `host_rdata` to 0. The RAM is not cleared.
- R10: One edge after the read conditions are lost, `host_rdata_oe` returns to 0 and `host_rdata` reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the host strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce1_n | input | 1 | Active-low host card enable |
| host_reg_n | input | 1 | Active-low register (attribute) space select |
| host_a | input | 10 | Host address; bit 0 must be 0, bits 9:1 are the word index |
| host_oe_n | input | 1 | Active-low host output enable (read strobe) |
| host_we_n | input | 1 | Active-low host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, 0x00 whenever not driven |
| host_rdata_oe | output | 1 | 1 while the block drives read data |
| ram_sel | output | 1 | Configuration RAM selected by the current enabled access |
| reg_sel | output | 8 | One-hot select of the configuration register being accessed |

## Verification
On every cycle the assertions check several rules. No select appears without full qualification, and the two select groups never overlap. An enabled write strobe always moves the machine to `ST_WRITE`, which suppresses read drive. A commit only ever follows a sampled low strobe. Each configuration register keeps its value unless it is the target of a commit. Read drive only follows a sampled, enabled read. The bench scenarios show what a property cannot: the actual byte in each RAM word and register, that the last data held before the strobe rises is the data stored, that an aborted or disqualified write leaves the target unchanged, and that reset clears the registers but not the RAM.

// File: rtl/attr_pkg.sv
`timescale 1ns/1ps
package attr_pkg;

    // Access machine states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_t;

    // Target region addressed by the word index
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_CFG  = 2'd2
    } region_t;

endpackage

// File: rtl/attr_addr_decode.sv
`timescale 1ns/1ps
module attr_addr_decode
    import attr_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int RAM_WORDS = 256,
    parameter int CFG_REGS  = 8
) (
    input  logic                          ce1_n,
    input  logic                          reg_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          strobe_act,
    output logic                          cen,
    output region_t                       region,
    output logic [$clog2(RAM_WORDS)-1:0]  ram_addr,
    output logic [$clog2(CFG_REGS)-1:0]   cfg_addr,
    output logic                          ram_sel,
    output logic [CFG_REGS-1:0]           reg_sel
);

    localparam int IDX_W  = ADDR_W - 1;
    localparam int RAM_AW = $clog2(RAM_WORDS);
    localparam int CFG_AW = $clog2(CFG_REGS);
    localparam logic [IDX_W-1:0] CFG_LO  = IDX_W'(RAM_WORDS);
    localparam logic [IDX_W-1:0] CFG_END = IDX_W'(RAM_WORDS + CFG_REGS);

    logic [IDX_W-1:0] idx;

    // Even addresses only: bit 0 is part of the qualification
    assign idx = addr[ADDR_W-1:1];
    assign cen = ~ce1_n & ~addr[0] & ~reg_n;

    always_comb begin
        if (idx < CFG_LO) begin
            region = RGN_RAM;
        end else if (idx < CFG_END) begin
            region = RGN_CFG;
        end else begin
            region = RGN_NONE;
        end
    end

    // The register block base is a multiple of the register count,
    // so the low index bits give the register number directly.
    assign ram_addr = idx[RAM_AW-1:0];
    assign cfg_addr = idx[CFG_AW-1:0];

    assign ram_sel = cen & strobe_act & (region == RGN_RAM);

    generate
        for (genvar k = 0; k < CFG_REGS; k++) begin : g_sel
            assign reg_sel[k] = cen & strobe_act & (region == RGN_CFG)
                              & (cfg_addr == CFG_AW'(k));
        end
    endgenerate

endmodule

// File: rtl/attr_access_fsm.sv
`timescale 1ns/1ps
module attr_access_fsm
    import attr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cen,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_active,
    output logic wr_commit,
    output logic capture
);

    acc_state_t state_q;
    acc_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_READ: begin
                if (cen && !we_n) begin
                    state_d = ST_WRITE;          // write wins over read
                end else if (cen && !oe_n) begin
                    state_d = ST_READ;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (we_n) begin
                    state_d = ST_IDLE;           // commit or late abort
                end else if (!cen) begin
                    state_d = ST_IDLE;           // abort
                end else begin
                    state_d = ST_WRITE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_active = (state_q == ST_READ);
        wr_commit = (state_q == ST_WRITE) && we_n && cen;
        capture   = cen && !we_n;
    end

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cen && !we_n) |=> (state_q == ST_WRITE));

    // R5
    commit_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(cen && !we_n));

    // R6
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && !we_n && !cen) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/attr_cfg_regs.sv
`timescale 1ns/1ps
module attr_cfg_regs #(
    parameter int DATA_W   = 8,
    parameter int CFG_REGS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(CFG_REGS)-1:0]  wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [$clog2(CFG_REGS)-1:0]  rd_addr,
    output logic [DATA_W-1:0]            rd_data
);

    localparam int CFG_AW = $clog2(CFG_REGS);

    logic [DATA_W-1:0] bank [CFG_REGS];

    generate
        for (genvar k = 0; k < CFG_REGS; k++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank[k] <= '0;
                end else if (wr_en && (wr_addr == CFG_AW'(k))) begin
                    bank[k] <= wr_data;
                end
            end

            // R5
            cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && (wr_addr == CFG_AW'(k))) |=> $stable(bank[k]));

            // R5
            cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (wr_addr == CFG_AW'(k))) |=> (bank[k] == $past(wr_data)));
        end
    endgenerate

    assign rd_data = bank[rd_addr];

endmodule

// File: rtl/attr_cfg_ram.sv
`timescale 1ns/1ps
module attr_cfg_ram #(
    parameter int DATA_W    = 8,
    parameter int RAM_WORDS = 256
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [$clog2(RAM_WORDS)-1:0]  wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [$clog2(RAM_WORDS)-1:0]  rd_addr,
    output logic [DATA_W-1:0]             rd_data
);

    logic [DATA_W-1:0] mem [RAM_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/attr_host_port.sv
`timescale 1ns/1ps
module attr_host_port
    import attr_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int RAM_WORDS = 256,
    parameter int CFG_REGS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_ce1_n,
    input  logic                 host_reg_n,
    input  logic [ADDR_W-1:0]    host_a,
    input  logic                 host_oe_n,
    input  logic                 host_we_n,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 host_rdata_oe,
    output logic                 ram_sel,
    output logic [CFG_REGS-1:0]  reg_sel
);

    localparam int RAM_AW = $clog2(RAM_WORDS);
    localparam int CFG_AW = $clog2(CFG_REGS);

    logic              cen;
    logic              strobe_act;
    region_t           region;
    logic [RAM_AW-1:0] ram_addr;
    logic [CFG_AW-1:0] cfg_addr;
    logic              rd_active;
    logic              wr_commit;
    logic              capture;

    region_t           hold_region;
    logic [RAM_AW-1:0] hold_ram_addr;
    logic [CFG_AW-1:0] hold_cfg_addr;
    logic [DATA_W-1:0] hold_data;

    logic              ram_we;
    logic              cfg_we;
    logic [DATA_W-1:0] ram_rd;
    logic [DATA_W-1:0] cfg_rd;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign strobe_act = ~host_oe_n | ~host_we_n;

    attr_addr_decode #(
        .ADDR_W    (ADDR_W),
        .RAM_WORDS (RAM_WORDS),
        .CFG_REGS  (CFG_REGS)
    ) u_decode (
        .ce1_n      (host_ce1_n),
        .reg_n      (host_reg_n),
        .addr       (host_a),
        .strobe_act (strobe_act),
        .cen        (cen),
        .region     (region),
        .ram_addr   (ram_addr),
        .cfg_addr   (cfg_addr),
        .ram_sel    (ram_sel),
        .reg_sel    (reg_sel)
    );

    attr_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cen       (cen),
        .oe_n      (host_oe_n),
        .we_n      (host_we_n),
        .rd_active (rd_active),
        .wr_commit (wr_commit),
        .capture   (capture)
    );

    // Address and data of the last cycle the write strobe was held low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_region   <= RGN_NONE;
            hold_ram_addr <= '0;
            hold_cfg_addr <= '0;
            hold_data     <= '0;
        end else if (capture) begin
            hold_region   <= region;
            hold_ram_addr <= ram_addr;
            hold_cfg_addr <= cfg_addr;
            hold_data     <= host_wdata;
        end
    end

    assign ram_we = wr_commit && (hold_region == RGN_RAM);
    assign cfg_we = wr_commit && (hold_region == RGN_CFG);

    attr_cfg_ram #(
        .DATA_W    (DATA_W),
        .RAM_WORDS (RAM_WORDS)
    ) u_ram (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_addr (hold_ram_addr),
        .wr_data (hold_data),
        .rd_addr (ram_addr),
        .rd_data (ram_rd)
    );

    attr_cfg_regs #(
        .DATA_W   (DATA_W),
        .CFG_REGS (CFG_REGS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (hold_cfg_addr),
        .wr_data (hold_data),
        .rd_addr (cfg_addr),
        .rd_data (cfg_rd)
    );

    always_comb begin
        unique case (region)
            RGN_RAM: rd_mux = ram_rd;
            RGN_CFG: rd_mux = cfg_rd;
            default: rd_mux = '0;
        endcase
    end

    // Registered read data, loaded only for a qualified read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (cen && !host_oe_n && host_we_n) begin
            rdata_q <= rd_mux;
        end else begin
            rdata_q <= '0;
        end
    end

    assign host_rdata_oe = rd_active;
    assign host_rdata    = rd_active ? rdata_q : '0;

    // R1
    gated_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ce1_n || host_a[0] || host_reg_n) |-> (!ram_sel && (reg_sel == '0)));

    // R3
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, reg_sel}));

    // R7
    read_follows_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata_oe |-> $past(cen && !host_oe_n && host_we_n));

    // R4
    empty_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata_oe && $past(region == RGN_NONE)) |-> (host_rdata == '0));

endmodule

// File: tb/attr_host_port_test.sv
`timescale 1ns/1ps
module attr_host_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_ce1_n = 1'b1;
    logic       host_reg_n = 1'b1;
    logic [9:0] host_a = '0;
    logic       host_oe_n = 1'b1;
    logic       host_we_n = 1'b1;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rdata_oe;
    logic       ram_sel;
    logic [7:0] reg_sel;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    attr_host_port uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_ce1_n    (host_ce1_n),
        .host_reg_n    (host_reg_n),
        .host_a        (host_a),
        .host_oe_n     (host_oe_n),
        .host_we_n     (host_we_n),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .host_rdata_oe (host_rdata_oe),
        .ram_sel       (ram_sel),
        .reg_sel       (reg_sel)
    );

    typedef struct packed {
        logic       wr;
        logic       ce1_n;
        logic       reg_n;
        logic [9:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic       exp_oe;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 10'd0,   8'h11, 8'h00, 1'b0},  // R2 RAM word 0
        '{1'b1, 1'b0, 1'b0, 10'd510, 8'hA5, 8'h00, 1'b0},  // R2 RAM word 255
        '{1'b1, 1'b0, 1'b0, 10'd2,   8'h42, 8'h00, 1'b0},  // R2 RAM word 1
        '{1'b1, 1'b0, 1'b0, 10'd512, 8'h3C, 8'h00, 1'b0},  // R3 cfg 0
        '{1'b1, 1'b0, 1'b0, 10'd526, 8'hC3, 8'h00, 1'b0},  // R3 cfg 7
        '{1'b1, 1'b0, 1'b0, 10'd528, 8'h77, 8'h00, 1'b0},  // R4 index 264
        '{1'b1, 1'b0, 1'b0, 10'd3,   8'h99, 8'h00, 1'b0},  // R1 odd address
        '{1'b1, 1'b1, 1'b0, 10'd2,   8'h88, 8'h00, 1'b0},  // R1 card enable high
        '{1'b1, 1'b0, 1'b1, 10'd514, 8'hEE, 8'h00, 1'b0},  // R1 register select high
        '{1'b0, 1'b0, 1'b0, 10'd0,   8'h00, 8'h11, 1'b1},  // R2
        '{1'b0, 1'b0, 1'b0, 10'd510, 8'h00, 8'hA5, 1'b1},  // R2
        '{1'b0, 1'b0, 1'b0, 10'd2,   8'h00, 8'h42, 1'b1},  // R1 word 1 untouched
        '{1'b0, 1'b0, 1'b0, 10'd512, 8'h00, 8'h3C, 1'b1},  // R3, R4 cfg 0 untouched
        '{1'b0, 1'b0, 1'b0, 10'd526, 8'h00, 8'hC3, 1'b1},  // R3
        '{1'b0, 1'b0, 1'b0, 10'd528, 8'h00, 8'h00, 1'b1},  // R4 empty index reads 0
        '{1'b0, 1'b0, 1'b0, 10'd514, 8'h00, 8'h00, 1'b1},  // R1, R9 cfg 1 still reset
        '{1'b0, 1'b0, 1'b0, 10'd513, 8'h00, 8'h00, 1'b0},  // R1 odd read
        '{1'b0, 1'b1, 1'b0, 10'd512, 8'h00, 8'h00, 1'b0},  // R1 card enable high
        '{1'b0, 1'b0, 1'b1, 10'd0,   8'h00, 8'h00, 1'b0}   // R1 register select high
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected {ram_sel, reg_sel} from the currently driven inputs
    function automatic logic [8:0] exp_sel();
        logic [8:0] r;
        logic [8:0] idx;
        r   = '0;
        idx = host_a[9:1];
        if (!host_ce1_n && !host_reg_n && !host_a[0] && (!host_oe_n || !host_we_n)) begin
            if (idx < 9'd256)      r[8] = 1'b1;
            else if (idx < 9'd264) r[idx[2:0]] = 1'b1;
        end
        return r;
    endfunction

    task automatic idle_bus();
        host_ce1_n = 1'b1;
        host_reg_n = 1'b1;
        host_oe_n  = 1'b1;
        host_we_n  = 1'b1;
    endtask

    task automatic do_write(input logic ce1_n, input logic reg_n,
                            input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        host_ce1_n = ce1_n; host_reg_n = reg_n; host_a = a;
        host_wdata = d; host_we_n = 1'b0;
        #1;
        check("R1/R2/R3", "write selects", {ram_sel, reg_sel}, exp_sel());
        @(posedge clk);
        @(negedge clk);
        host_we_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        idle_bus();
    endtask

    task automatic do_read(input logic ce1_n, input logic reg_n, input logic [9:0] a,
                           input logic [7:0] exp, input logic exp_oe, input string req);
        @(negedge clk);
        host_ce1_n = ce1_n; host_reg_n = reg_n; host_a = a; host_oe_n = 1'b0;
        #1;
        check("R7", "oe before edge", host_rdata_oe, 1'b0);
        check("R1/R2/R3", "read selects", {ram_sel, reg_sel}, exp_sel());
        @(posedge clk);
        @(negedge clk);
        check(req, "read oe", host_rdata_oe, exp_oe);
        check(req, "read data", host_rdata, exp);
        host_oe_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R10", "oe after read", host_rdata_oe, 1'b0);
        check("R10", "data after read", host_rdata, 8'h00);
        idle_bus();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check("R9", "reset oe", host_rdata_oe, 1'b0);
        check("R9", "reset data", host_rdata, 8'h00);
        check("R9", "reset selects", {ram_sel, reg_sel}, 9'h000);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                do_write(VECS[i].ce1_n, VECS[i].reg_n, VECS[i].addr, VECS[i].data);
            end else begin
                do_read(VECS[i].ce1_n, VECS[i].reg_n, VECS[i].addr,
                        VECS[i].exp, VECS[i].exp_oe, "R1/R2/R3/R4 table");
            end
        end

        // R5: strobe held three cycles with changing data, last value wins
        @(negedge clk);
        host_ce1_n = 1'b0; host_reg_n = 1'b0; host_a = 10'd516;
        host_wdata = 8'h10; host_we_n = 1'b0;
        @(posedge clk); @(negedge clk);
        host_wdata = 8'h20;
        @(posedge clk); @(negedge clk);
        host_wdata = 8'h30;
        @(posedge clk); @(negedge clk);
        host_we_n = 1'b1;
        host_wdata = 8'hFF;
        @(posedge clk); @(negedge clk);
        idle_bus();
        do_read(1'b0, 1'b0, 10'd516, 8'h30, 1'b1, "R5 last held data");

        // R6: card enable lost while strobe still low
        @(negedge clk);
        host_ce1_n = 1'b0; host_reg_n = 1'b0; host_a = 10'd522;
        host_wdata = 8'h5A; host_we_n = 1'b0;
        @(posedge clk); @(negedge clk);
        host_ce1_n = 1'b1;
        @(posedge clk); @(negedge clk);
        host_we_n = 1'b1;
        @(posedge clk); @(negedge clk);
        idle_bus();
        do_read(1'b0, 1'b0, 10'd522, 8'h00, 1'b1, "R6 aborted write");

        // R8: both strobes low, write wins
        @(negedge clk);
        host_ce1_n = 1'b0; host_reg_n = 1'b0; host_a = 10'd524;
        host_wdata = 8'h66; host_oe_n = 1'b0; host_we_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8", "oe with both strobes", host_rdata_oe, 1'b0);
        check("R8", "data with both strobes", host_rdata, 8'h00);
        host_we_n = 1'b1;
        @(posedge clk); @(negedge clk);
        idle_bus();
        @(posedge clk);
        do_read(1'b0, 1'b0, 10'd524, 8'h66, 1'b1, "R8 write committed");

        // R9: asynchronous reset during a read
        @(negedge clk);
        host_ce1_n = 1'b0; host_reg_n = 1'b0; host_a = 10'd512; host_oe_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9", "oe before reset", host_rdata_oe, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R9", "oe forced by reset", host_rdata_oe, 1'b0);
        check("R9", "data forced by reset", host_rdata, 8'h00);
        idle_bus();
        @(negedge clk);
        rst_n = 1'b1;
        do_read(1'b0, 1'b0, 10'd512, 8'h00, 1'b1, "R9 cfg cleared");
        do_read(1'b0, 1'b0, 10'd0, 8'h11, 1'b1, "R9 RAM kept");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule